// File: doc/BRIEF.md
# Reloading Countdown Timer with Sticky Interrupt

This block is a register-mapped countdown timer for a small peripheral subsystem. Software sets a start value and a control word. The counter then steps down by one on each pulse of a tick-enable strobe. Two external strobes supply the tick, and a control bit picks which one the counter follows. The strobes are produced elsewhere; this block only consumes them.

When the counter is at zero and takes one more step, it has underflowed, and it raises an interrupt flag. The flag stays set until software writes to a dedicated clear register, and the written data does not matter. A control bit sets what the counter does after an underflow:
- In periodic mode it reloads the stored start value.
- In free-running mode it wraps to all-ones.

The counter width is a parameter, and both 16-bit and 32-bit instances are used. Bus access is a single-cycle register port. Writes take effect at the next clock edge. Read data is combinational from the address.

Top module: `ctimer_top`

## Requirements
- R1: After reset, the load, count and control registers all read as zero and `irq` is low.
- R2: A write to the load register (byte address 0x0) stores the value and copies it into the counter. The write takes priority over any tick in the same cycle, and the new value reads back from the count register (0x4).
- R3: When control bit 7 is 1, the counter decreases by one on each cycle in which the selected tick input is high. When bit 7 is 0, the count holds.
- R4: When control bit 3 is 1, the counter follows `tick_fast`. When bit 3 is 0, it follows `tick_slow`. Pulses on the input that is not selected have no effect.
- R5: A counting step taken while the count is zero is an underflow, and it sets `irq`. With control bit 6 set (periodic), the counter reloads from the load register.
- R6: With control bit 6 clear, an underflow wraps the counter to all-ones for its width, and `irq` is still set.
- R7: A write of any data to the clear register (0xC) deasserts `irq`. If an underflow happens in the same cycle, `irq` stays set.
- R8: The control register (0x8) reads back bits 7, 6 and 3 as written. All other bits read as zero.
- R9: The count register is read-only: a write to 0x4 leaves the count unchanged.
- R10: A 16-bit instance behaves like the 32-bit default over the same stimulus, and its wrap value is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Slow tick-enable strobe |
| tick_fast | input | 1 | Fast tick-enable strobe |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
On every cycle, the assertions check the following:
- the single-step decrement;
- holding while no step is taken;
- the reload or wrap after an underflow, chosen by mode;
- the copy-on-load;
- the rule that `irq` is set or cleared only by underflow or a clear write, with underflow winding;
- the masking of control readback.

The interaction with software needs the bench's scenarios. These cover:
- whether the selected tick is honoured over the other;
- counts reached after several steps across more than one reload;
- a write to the read-only count being ignored;
- the 16-bit wrap value.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  localparam int REG_ADDR_W   = 4;
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_FAST_BIT = 3;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [REG_ADDR_W-1:0] addr);
    return reg_sel_e'(addr[3:2]);
  endfunction
endpackage

// File: rtl/ctimer_regs.sv
module ctimer_regs
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]      count,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [CNT_W-1:0]      load_val,
  output logic                  ctl_en,
  output logic                  ctl_per,
  output logic                  ctl_fast,
  output logic                  load_wr,
  output logic                  clr_wr
);
  reg_sel_e sel;
  logic     ctl_wr;
  logic     rd;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] load_ext;
  logic [DATA_W-1:0] count_ext;
  logic [1:0] unused_addr;

  assign sel         = decode_sel(bus_addr);
  assign unused_addr = bus_addr[1:0];
  assign load_wr     = bus_en && bus_we && (sel == SEL_LOAD);
  assign ctl_wr      = bus_en && bus_we && (sel == SEL_CTRL);
  assign clr_wr      = bus_en && bus_we && (sel == SEL_CLEAR);
  assign rd          = bus_en && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_val <= '0;
      ctl_en   <= 1'b0;
      ctl_per  <= 1'b0;
      ctl_fast <= 1'b0;
    end else begin
      if (load_wr) load_val <= bus_wdata[CNT_W-1:0];
      if (ctl_wr) begin
        ctl_en   <= bus_wdata[CTL_EN_BIT];
        ctl_per  <= bus_wdata[CTL_PER_BIT];
        ctl_fast <= bus_wdata[CTL_FAST_BIT];
      end
    end
  end

  generate
    if (CNT_W == DATA_W) begin : g_full
      assign load_ext  = load_val;
      assign count_ext = count;
    end else begin : g_pad
      assign load_ext  = {{(DATA_W-CNT_W){1'b0}}, load_val};
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
    end
  endgenerate

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_BIT]   = ctl_en;
    ctl_word[CTL_PER_BIT]  = ctl_per;
    ctl_word[CTL_FAST_BIT] = ctl_fast;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_LOAD:  bus_rdata = load_ext;
        SEL_COUNT: bus_rdata = count_ext;
        SEL_CTRL:  bus_rdata = ctl_word;
        SEL_CLEAR: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctimer_core.sv
module ctimer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             ctl_en,
  input  logic             ctl_per,
  input  logic             ctl_fast,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] count,
  output logic             step,
  output logic             uf
);
  function automatic logic [CNT_W-1:0] after_step(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] reload,
    input logic             periodic
  );
    if (cur == '0) return periodic ? reload : '1;
    return cur - 1'b1;
  endfunction

  logic tick_sel;
  assign tick_sel = ctl_fast ? tick_fast : tick_slow;
  assign step     = ctl_en && tick_sel;
  assign uf       = step && !load_wr && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load_wr) count <= load_data;
    else if (step)    count <= after_step(count, load_val, ctl_per);
  end
endmodule

// File: rtl/ctimer_irq.sv
module ctimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (uf)     irq <= 1'b1;
    else if (clr_wr) irq <= 1'b0;
  end
endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_slow,
  input  logic                  tick_fast,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic             ctl_en, ctl_per, ctl_fast;
  logic             load_wr, clr_wr;
  logic             step, uf;

  ctimer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
    .bus_rdata(bus_rdata), .load_val(load_val), .ctl_en(ctl_en),
    .ctl_per(ctl_per), .ctl_fast(ctl_fast), .load_wr(load_wr), .clr_wr(clr_wr)
  );

  ctimer_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .ctl_en(ctl_en), .ctl_per(ctl_per), .ctl_fast(ctl_fast),
    .load_wr(load_wr), .load_val(load_val), .load_data(bus_wdata[CNT_W-1:0]),
    .count(count), .step(step), .uf(uf)
  );

  ctimer_irq irq_i (
    .clk(clk), .rst_n(rst_n), .uf(uf), .clr_wr(clr_wr), .irq(irq)
  );
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  irq,
  input logic [CNT_W-1:0]      count,
  input logic [CNT_W-1:0]      load_val,
  input logic                  ctl_per,
  input logic                  load_wr,
  input logic                  clr_wr,
  input logic                  step,
  input logic                  uf
);
  localparam logic [DATA_W-1:0] CTL_MASK =
    (DATA_W'(1) << CTL_EN_BIT) | (DATA_W'(1) << CTL_PER_BIT) | (DATA_W'(1) << CTL_FAST_BIT);

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count == $past(bus_wdata[CNT_W-1:0]));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_wr && count != '0) |=> count == $past(count) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_wr) |=> $stable(count));
  a_r5_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq);
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && ctl_per) |=> count == $past(load_val));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !ctl_per) |=> count == {CNT_W{1'b1}});
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !uf) |=> !irq);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf && !clr_wr) |=> $stable(irq));
  a_r8_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr[3:2] == 2'd2) |-> (bus_rdata & ~CTL_MASK) == '0);
endmodule

bind ctimer_top ctimer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .count(count),
  .load_val(load_val), .ctl_per(ctl_per), .load_wr(load_wr), .clr_wr(clr_wr),
  .step(step), .uf(uf)
);

// File: tb/ctimer_top_tb_top.sv
`timescale 1ns/1ps
module ctimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0, tick_fast = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata32, rdata16;
  logic        irq32, irq16;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ctimer_top #(.DATA_W(32), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata32), .irq(irq32));

  ctimer_top #(.DATA_W(32), .CNT_W(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata16), .irq(irq16));

  typedef struct packed {
    logic [31:0] load;
    logic [7:0]  ctl;
    logic [3:0]  nslow;
    logic [3:0]  nfast;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'd10, 8'hC0, 4'd3, 4'd0, 32'd7,         1'b0},  // R3 slow count
    '{32'd10, 8'hC0, 4'd0, 4'd3, 32'd10,        1'b0},  // R4 fast ignored
    '{32'd10, 8'hC8, 4'd2, 4'd4, 32'd6,         1'b0},  // R4 fast selected
    '{32'd2,  8'hC0, 4'd3, 4'd0, 32'd2,         1'b1},  // R5 reload
    '{32'd2,  8'h80, 4'd3, 4'd0, 32'hFFFF_FFFF, 1'b1},  // R6 wrap
    '{32'd5,  8'h40, 4'd4, 4'd0, 32'd5,         1'b0},  // R3 stopped
    '{32'd0,  8'hC0, 4'd1, 4'd0, 32'd0,         1'b1},  // R5 zero load
    '{32'd3,  8'hC0, 4'd9, 4'd0, 32'd2,         1'b1}   // R5 two reloads
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d32, output logic [31:0] d16);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d32 = rdata32; d16 = rdata16;
    bus_en = 1'b0;
  endtask

  task automatic pulse(input logic fast);
    @(negedge clk);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v32, v16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v32, v16); check("R1 load", v32, 0);
    rd(4'h4, v32, v16); check("R1 count", v32, 0);
    rd(4'h8, v32, v16); check("R1 ctrl", v32, 0);
    check("R1 irq", {31'b0, irq32}, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);
      wr(4'h0, VECS[i].load);
      wr(4'h8, {24'h0, VECS[i].ctl});
      for (int s = 0; s < int'(VECS[i].nslow); s++) pulse(1'b0);
      for (int f = 0; f < int'(VECS[i].nfast); f++) pulse(1'b1);
      rd(4'h4, v32, v16);
      check($sformatf("R3/R4/R5/R6 vec%0d count", i), v32, VECS[i].exp_cnt);
      check($sformatf("R10 vec%0d count16", i), v16, {16'h0, VECS[i].exp_cnt[15:0]});
      check($sformatf("R5 vec%0d irq", i), {31'b0, irq32}, {31'b0, VECS[i].exp_irq});
      check($sformatf("R10 vec%0d irq16", i), {31'b0, irq16}, {31'b0, VECS[i].exp_irq});
    end

    // R7 clear with arbitrary data (irq set from last vector)
    wr(4'hC, 32'hDEAD_BEEF);
    check("R7 clear", {31'b0, irq32}, 0);

    // R8 control readback masking
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v32, v16); check("R8 ctrl mask", v32, 32'hC8);
    wr(4'h8, 32'h0);

    // R2 load copies to count, load readback
    wr(4'h0, 32'h0001_2345);
    rd(4'h4, v32, v16); check("R2 count copy", v32, 32'h0001_2345);
    check("R10 count16 copy", v16, 32'h2345);
    rd(4'h0, v32, v16); check("R2 load readback", v32, 32'h0001_2345);

    // R9 count register write ignored
    wr(4'h4, 32'h0000_0099);
    rd(4'h4, v32, v16); check("R9 count read-only", v32, 32'h0001_2345);

    // R7 underflow and clear in the same cycle: irq stays set
    wr(4'h0, 32'h0);
    wr(4'h8, 32'hC0);
    wr(4'hC, 32'h0);
    check("R7 precondition", {31'b0, irq32}, 0);
    @(negedge clk);
    tick_slow = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h5;
    @(negedge clk);
    tick_slow = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    check("R7 underflow wins", {31'b0, irq32}, 1);
    wr(4'hC, 32'h0);
    check("R7 later clear", {31'b0, irq32}, 0);

    // R2 load write in same cycle as a tick takes priority
    @(negedge clk);
    tick_slow = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'd40;
    @(negedge clk);
    tick_slow = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    rd(4'h4, v32, v16); check("R2 load beats tick", v32, 32'd40);

    finish_run();
  end
endmodule